// File: doc/BRIEF.md
# Single-Beat Write-Readback Bus Self-Test Sequencer

This block runs one self-test against a memory-mapped location through a generic bus-master request interface. After reset is released, a warm-up counter runs to completion. The block then puts a fixed address, byte-enable pattern and data word on its qualifier outputs and raises a write request for one single-beat transfer. When that transfer ends, it turns the direction to read, waits one idle cycle, and raises a read request to the same address. It captures the returned word on the read-valid strobe and compares it with the written word, byte by byte, under the byte enables.

A request stays high until the bus reports a last acknowledge, a timeout or a bus error. A timeout or bus error on the write ends the test at once, and the read is never issued. The result is a set of sticky flags: done, pass, fail and a two-bit error code that tells which phase went wrong. These flags hold until the next reset. Integration is a matter of pointing the address and data parameters at a scratch location and watching the flags.

Top module: `sbm_wrrd_seq`

## Requirements
- R1: While rst_ni is low, wr_req_o, rd_req_o, done_o, pass_o and fail_o are low and err_code_o is 0.
- R2: wr_req_o is first high after the 129th rising clock edge following reset release. This is 2^DELAY_W warm-up edges with DELAY_W=7, plus one setup edge. No request is raised earlier.
- R3: While a write is requested, rnw_o=0, addr_o=TEST_ADDR, be_o=TEST_BE and wdata_o=TEST_DATA. These values are already present in the cycle before wr_req_o rises.
- R4: A request stays high in every cycle until last_ack_i, timeout_i or bus_err_i is sampled high. It is low in the cycle after that sample. wr_req_o and rd_req_o are never high together.
- R5: After a write that ends without a fault, there is exactly one cycle with both requests low, with rnw_o=1 and addr_o unchanged. Then rd_req_o rises with rnw_o=1 and the same address.
- R6: A timeout or bus error during the write sets done_o and fail_o, and sets err_code_o=1, in the same cycle that wr_req_o falls. No read is ever requested.
- R7: A timeout or bus error during the read sets done_o and fail_o, and sets err_code_o=2, two cycles after the terminating sample.
- R8: Read data is captured on rdata_vld_i while the read is requested. Two cycles after the read ends, done_o rises. pass_o is set with err_code_o=0 when every enabled byte (be bit b covers data bits 8b+7:8b) matches TEST_DATA; a disabled byte is ignored. Otherwise fail_o is set with err_code_o=3, which includes the case where no strobe was seen.
- R9: Once done_o is high, it and the verdict hold, and both requests stay low, until the next reset.
- R10: When a fault input and last_ack_i are high in the same terminating cycle, the fault wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_req_o | output | 1 | Write request, held until termination |
| rd_req_o | output | 1 | Read request, held until termination |
| rnw_o | output | 1 | Direction qualifier, 1 = read |
| addr_o | output | ADDR_W | Transfer address |
| be_o | output | DATA_W/8 | Byte enables |
| wdata_o | output | DATA_W | Write data |
| last_ack_i | input | 1 | Last acknowledge of current transfer |
| timeout_i | input | 1 | Transfer timeout |
| bus_err_i | input | 1 | Transfer bus error |
| rdata_i | input | DATA_W | Read data |
| rdata_vld_i | input | 1 | Read data valid strobe |
| done_o | output | 1 | Test finished (sticky) |
| pass_o | output | 1 | Readback matched (sticky) |
| fail_o | output | 1 | Test failed (sticky) |
| err_code_o | output | 2 | 0 none, 1 write fault, 2 read fault, 3 data mismatch |

## Verification
The sequence is driven through clean acknowledges with different latencies, write timeouts, and write bus errors that coincide with an acknowledge. It is also driven through read bus errors, reads that end without a strobe, and strobes that arrive before the terminating cycle. Readback words that differ only in a disabled byte must pass, and words that differ in an enabled byte must fail. This separates real masking from a full-word compare. The write-fault cases show whether the read is truly skipped. Early-strobe cases with junk data on the final cycle show whether capture follows the strobe or simply the end of the transfer.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [2:0] {
    ST_WARMUP,
    ST_WR_SETUP,
    ST_WR_BUSY,
    ST_RD_SETUP,
    ST_RD_BUSY,
    ST_JUDGE,
    ST_FINISHED
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_WR   = 2'd1,
    ERR_RD   = 2'd2,
    ERR_DATA = 2'd3
  } err_code_e;
endpackage

// File: rtl/sbm_warmup.sv
module sbm_warmup #(
  parameter int unsigned CNT_W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q == CntMax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sbm_req_chan.sv
module sbm_req_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic last_ack_i,
  input  logic timeout_i,
  input  logic bus_err_i,
  output logic req_o,
  output logic end_o,
  output logic fault_o
);
  logic req_q;

  assign req_o   = req_q;
  assign end_o   = req_q & (last_ack_i | timeout_i | bus_err_i);
  // fault outranks a simultaneous acknowledge
  assign fault_o = req_q & (timeout_i | bus_err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       req_q <= 1'b0;
    else if (launch_i) req_q <= 1'b1;
    else if (end_o)    req_q <= 1'b0;
  end
endmodule

// File: rtl/sbm_rd_check.sv
module sbm_rd_check #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] exp_data_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              match_o
);
  logic [DATA_W-1:0] cap_q;
  logic              seen_q;
  logic [BE_W-1:0]   lane_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      seen_q <= 1'b0;
    end else if (cap_en_i) begin
      cap_q  <= rdata_i;
      seen_q <= 1'b1;
    end
  end

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign lane_ok[b] = !be_i[b] || (cap_q[8*b +: 8] == exp_data_i[8*b +: 8]);
  end

  assign match_o = seen_q && (&lane_ok);
endmodule

// File: rtl/sbm_wrrd_seq.sv
module sbm_wrrd_seq
  import sbm_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DELAY_W = 7,
  parameter logic [ADDR_W-1:0]     TEST_ADDR = ADDR_W'(32'h0000_1F40),
  parameter logic [DATA_W-1:0]     TEST_DATA = DATA_W'(32'hA5C3_5A3C),
  parameter logic [DATA_W/8-1:0]   TEST_BE   = (DATA_W/8)'(4'b1011)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                wr_req_o,
  output logic                rd_req_o,
  output logic                rnw_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W/8-1:0] be_o,
  output logic [DATA_W-1:0]   wdata_o,
  input  logic                last_ack_i,
  input  logic                timeout_i,
  input  logic                bus_err_i,
  input  logic [DATA_W-1:0]   rdata_i,
  input  logic                rdata_vld_i,
  output logic                done_o,
  output logic                pass_o,
  output logic                fail_o,
  output logic [1:0]          err_code_o
);
  localparam int unsigned BE_W = DATA_W / 8;

  seq_state_e        state_q;
  err_code_e         code_q;
  logic              rnw_q, done_q, pass_q, fail_q, rd_fault_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q;

  logic warm_done, wr_end, wr_fault, rd_end, rd_fault, data_match;

  sbm_warmup #(.CNT_W(DELAY_W)) u_warmup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_WARMUP),
    .expired_o (warm_done)
  );

  sbm_req_chan u_wr_chan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (state_q == ST_WR_SETUP),
    .last_ack_i (last_ack_i),
    .timeout_i  (timeout_i),
    .bus_err_i  (bus_err_i),
    .req_o      (wr_req_o),
    .end_o      (wr_end),
    .fault_o    (wr_fault)
  );

  sbm_req_chan u_rd_chan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (state_q == ST_RD_SETUP),
    .last_ack_i (last_ack_i),
    .timeout_i  (timeout_i),
    .bus_err_i  (bus_err_i),
    .req_o      (rd_req_o),
    .end_o      (rd_end),
    .fault_o    (rd_fault)
  );

  sbm_rd_check #(.DATA_W(DATA_W)) u_rd_check (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_en_i   ((state_q == ST_RD_BUSY) && rdata_vld_i),
    .rdata_i    (rdata_i),
    .exp_data_i (TEST_DATA),
    .be_i       (TEST_BE),
    .match_o    (data_match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_WARMUP;
      rnw_q      <= 1'b0;
      addr_q     <= '0;
      be_q       <= '0;
      wdata_q    <= '0;
      done_q     <= 1'b0;
      pass_q     <= 1'b0;
      fail_q     <= 1'b0;
      code_q     <= ERR_NONE;
      rd_fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WARMUP: if (warm_done) begin
          // qualifiers settle one cycle ahead of the request
          addr_q  <= TEST_ADDR;
          be_q    <= TEST_BE;
          wdata_q <= TEST_DATA;
          rnw_q   <= 1'b0;
          state_q <= ST_WR_SETUP;
        end
        ST_WR_SETUP: state_q <= ST_WR_BUSY;
        ST_WR_BUSY: if (wr_end) begin
          if (wr_fault) begin
            done_q  <= 1'b1;
            fail_q  <= 1'b1;
            code_q  <= ERR_WR;
            state_q <= ST_FINISHED;
          end else begin
            rnw_q   <= 1'b1;
            state_q <= ST_RD_SETUP;
          end
        end
        ST_RD_SETUP: state_q <= ST_RD_BUSY;
        ST_RD_BUSY: if (rd_end) begin
          rd_fault_q <= rd_fault;
          state_q    <= ST_JUDGE;
        end
        ST_JUDGE: begin
          done_q  <= 1'b1;
          state_q <= ST_FINISHED;
          if (rd_fault_q) begin
            fail_q <= 1'b1;
            code_q <= ERR_RD;
          end else if (data_match) begin
            pass_q <= 1'b1;
          end else begin
            fail_q <= 1'b1;
            code_q <= ERR_DATA;
          end
        end
        ST_FINISHED: ;
        default: state_q <= ST_FINISHED;
      endcase
    end
  end

  assign rnw_o      = rnw_q;
  assign addr_o     = addr_q;
  assign be_o       = be_q;
  assign wdata_o    = wdata_q;
  assign done_o     = done_q;
  assign pass_o     = pass_q;
  assign fail_o     = fail_q;
  assign err_code_o = code_q;
endmodule

// File: rtl/sbm_seq_chk.sv
module sbm_seq_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DELAY_W = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_req_o,
  input logic                rd_req_o,
  input logic                rnw_o,
  input logic [ADDR_W-1:0]   addr_o,
  input logic [DATA_W/8-1:0] be_o,
  input logic [DATA_W-1:0]   wdata_o,
  input logic                last_ack_i,
  input logic                timeout_i,
  input logic                bus_err_i,
  input logic                done_o,
  input logic                pass_o,
  input logic                fail_o,
  input logic [1:0]          err_code_o
);
  localparam int unsigned CW = DELAY_W + 2;
  localparam logic [CW-1:0] WarmEdges = CW'(1) << DELAY_W;

  logic [CW-1:0] cyc_q;
  logic term, flt;

  assign term = last_ack_i | timeout_i | bus_err_i;
  assign flt  = timeout_i | bus_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != {CW{1'b1}}) cyc_q <= cyc_q + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !wr_req_o && !rd_req_o && !done_o && !pass_o && !fail_o);

  p_warmup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> cyc_q > WarmEdges);

  p_wr_qual_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_req_o) |-> !rnw_o && $stable(rnw_o) && $stable(addr_o) &&
                        $stable(be_o) && $stable(wdata_o));

  p_req_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_req_o && rd_req_o));

  p_wr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !term |=> wr_req_o);

  p_wr_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && term |=> !wr_req_o);

  p_rd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !term |=> rd_req_o);

  p_rd_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && term |=> !rd_req_o);

  p_rd_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_o) |-> !$past(wr_req_o) && rnw_o && $stable(rnw_o) && $stable(addr_o));

  p_wr_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && flt |=> done_o && fail_o && err_code_o == 2'd1);

  p_rd_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && flt |=> ##1 done_o && fail_o && err_code_o == 2'd2);

  p_verdict_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |-> done_o && !(pass_o && fail_o) &&
                           (pass_o == (err_code_o == 2'd0)));

  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && $stable(pass_o) && $stable(fail_o) &&
               $stable(err_code_o) && !wr_req_o && !rd_req_o);
endmodule

bind sbm_wrrd_seq sbm_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .DELAY_W(DELAY_W)
) u_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_req_o   (wr_req_o),
  .rd_req_o   (rd_req_o),
  .rnw_o      (rnw_o),
  .addr_o     (addr_o),
  .be_o       (be_o),
  .wdata_o    (wdata_o),
  .last_ack_i (last_ack_i),
  .timeout_i  (timeout_i),
  .bus_err_i  (bus_err_i),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .fail_o     (fail_o),
  .err_code_o (err_code_o)
);

// File: tb/tb_sbm_wrrd_seq.sv
module tb_sbm_wrrd_seq;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned DLY = 7;
  localparam logic [AW-1:0]   T_ADDR = 32'h0000_1F40;
  localparam logic [DW-1:0]   T_DATA = 32'hA5C3_5A3C;
  localparam logic [DW/8-1:0] T_BE   = 4'b1011;

  typedef struct packed {
    logic       pass;
    logic       fail;
    logic [1:0] code;
  } verdict_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_req_o, rd_req_o, rnw_o, done_o, pass_o, fail_o;
  logic [AW-1:0] addr_o;
  logic [DW/8-1:0] be_o;
  logic [DW-1:0] wdata_o;
  logic [1:0] err_code_o;
  logic last_ack_i = 0, timeout_i = 0, bus_err_i = 0, rdata_vld_i = 0;
  logic [DW-1:0] rdata_i = '0;

  int total = 0, bad = 0, mon_hits = 0;
  bit finished = 0, mon_seen = 0;
  verdict_t sb_q[$];

  always #4 clk = ~clk;

  sbm_wrrd_seq #(
    .ADDR_W(AW), .DATA_W(DW), .DELAY_W(DLY),
    .TEST_ADDR(T_ADDR), .TEST_DATA(T_DATA), .TEST_BE(T_BE)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_req_o(wr_req_o), .rd_req_o(rd_req_o),
    .rnw_o(rnw_o), .addr_o(addr_o), .be_o(be_o), .wdata_o(wdata_o),
    .last_ack_i(last_ack_i), .timeout_i(timeout_i), .bus_err_i(bus_err_i),
    .rdata_i(rdata_i), .rdata_vld_i(rdata_vld_i), .done_o(done_o),
    .pass_o(pass_o), .fail_o(fail_o), .err_code_o(err_code_o)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // monitor: pops the expected verdict when done_o first appears
  always @(negedge clk) begin
    if (!rst_ni) mon_seen <= 0;
    else if (done_o && !mon_seen) begin
      verdict_t got, exp;
      mon_seen <= 1;
      mon_hits++;
      got = '{pass: pass_o, fail: fail_o, code: err_code_o};
      if (sb_q.size() == 0) chk(0, "R8", "unexpected verdict", 64'(got), 0);
      else begin
        exp = sb_q.pop_front();
        chk(got == exp, "R6/R7/R8", "verdict {pass,fail,code}", 64'(got), 64'(exp));
      end
    end
  end

  task automatic drive_term(input int kind);
    last_ack_i = (kind == 0 || kind == 3);
    timeout_i  = (kind == 1);
    bus_err_i  = (kind == 2 || kind == 3);
  endtask

  // kind: 0 ack, 1 timeout, 2 bus error, 3 ack+bus error
  task automatic run_case(input string name, input int wr_lat, input int wr_kind,
                          input int rd_lat, input int rd_kind, input int vld_at,
                          input logic [DW-1:0] rd_val, input verdict_t exp);
    int n;
    logic [AW-1:0] p_addr; logic [DW/8-1:0] p_be; logic [DW-1:0] p_wd; logic p_rnw;
    bit wr_flt;
    $display("case %s", name);
    @(negedge clk);
    rst_ni = 0;
    drive_term(-1); rdata_vld_i = 0;
    repeat (3) @(negedge clk);
    chk(!wr_req_o && !rd_req_o && !done_o && !pass_o && !fail_o && err_code_o == 0,
        "R1", "outputs during reset", {wr_req_o, rd_req_o, done_o, pass_o, fail_o, err_code_o}, 0);
    sb_q.push_back(exp);
    rst_ni = 1;
    n = 0;
    p_addr = addr_o; p_be = be_o; p_wd = wdata_o; p_rnw = rnw_o;
    while (!wr_req_o && n < 400) begin
      p_addr = addr_o; p_be = be_o; p_wd = wdata_o; p_rnw = rnw_o;
      @(negedge clk); n++;
      if (rd_req_o) chk(0, "R2", "read before write", 1, 0);
    end
    chk(n == 129, "R2", "edges to first write request", n, 129);
    chk(addr_o == T_ADDR && be_o == T_BE && wdata_o == T_DATA && !rnw_o,
        "R3", "write qualifiers", {addr_o, wdata_o}, {T_ADDR, T_DATA});
    chk(p_addr == T_ADDR && p_be == T_BE && p_wd == T_DATA && !p_rnw,
        "R3", "qualifiers one cycle before request", {p_addr, p_wd}, {T_ADDR, T_DATA});
    for (int i = 0; i <= wr_lat; i++) begin
      if (i == wr_lat) drive_term(wr_kind);
      @(negedge clk);
      if (i < wr_lat) chk(wr_req_o == 1, "R4", "write request held", wr_req_o, 1);
    end
    drive_term(-1);
    chk(wr_req_o == 0, "R4", "write request dropped after termination", wr_req_o, 0);
    wr_flt = (wr_kind != 0);
    if (wr_flt) begin
      chk(done_o && fail_o && err_code_o == 1, "R6", "write fault verdict same cycle",
          {done_o, fail_o, err_code_o}, {1'b1, 1'b1, 2'd1});
      if (wr_kind == 3) chk(err_code_o == 1, "R10", "fault beats ack", err_code_o, 1);
    end else begin
      chk(!rd_req_o && rnw_o && addr_o == T_ADDR, "R5", "idle cycle before read",
          {rd_req_o, rnw_o, addr_o}, {1'b0, 1'b1, T_ADDR});
      @(negedge clk);
      chk(rd_req_o && rnw_o && addr_o == T_ADDR && be_o == T_BE, "R5", "read qualifiers",
          {rd_req_o, rnw_o, addr_o}, {1'b1, 1'b1, T_ADDR});
      for (int i = 0; i <= rd_lat; i++) begin
        rdata_vld_i = (i == vld_at);
        rdata_i = (i == vld_at) ? rd_val : 32'hDEAD_BEEF;
        if (i == rd_lat) drive_term(rd_kind);
        @(negedge clk);
        if (i < rd_lat) chk(rd_req_o == 1, "R4", "read request held", rd_req_o, 1);
      end
      drive_term(-1); rdata_vld_i = 0;
      chk(!rd_req_o && !done_o, "R4", "read dropped, no verdict yet",
          {rd_req_o, done_o}, 0);
      @(negedge clk);
      chk(done_o == 1, "R8", "done two cycles after read end", done_o, 1);
      if (rd_kind == 3) chk(err_code_o == 2, "R10", "fault beats ack on read", err_code_o, 2);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(done_o && !wr_req_o && !rd_req_o && pass_o == exp.pass && err_code_o == exp.code,
          "R9", "verdict held", {done_o, wr_req_o, rd_req_o, pass_o, err_code_o},
          {1'b1, 1'b0, 1'b0, exp.pass, exp.code});
      if (wr_flt) chk(!rd_req_o, "R6", "no read after write fault", rd_req_o, 0);
    end
  endtask

  initial begin
    run_case("clean", 2, 0, 3, 0, 3, T_DATA, '{1'b1, 1'b0, 2'd0});
    run_case("masked lane", 0, 0, 1, 0, 1, T_DATA ^ 32'h00FF_0000, '{1'b1, 1'b0, 2'd0});
    run_case("lane mismatch", 1, 0, 0, 0, 0, T_DATA ^ 32'h0000_0001, '{1'b0, 1'b1, 2'd3});
    run_case("write timeout", 3, 1, 0, 0, 0, T_DATA, '{1'b0, 1'b1, 2'd1});
    run_case("write err+ack", 0, 3, 0, 0, 0, T_DATA, '{1'b0, 1'b1, 2'd1});
    run_case("read bus err", 1, 0, 2, 2, 2, T_DATA, '{1'b0, 1'b1, 2'd2});
    run_case("read err+ack", 1, 0, 0, 3, 0, T_DATA, '{1'b0, 1'b1, 2'd2});
    run_case("no strobe", 1, 0, 2, 0, -1, T_DATA, '{1'b0, 1'b1, 2'd3});
    run_case("early strobe", 1, 0, 4, 0, 1, T_DATA, '{1'b1, 1'b0, 2'd0});
    @(negedge clk);
    chk(sb_q.size() == 0 && mon_hits == 9, "R8", "all verdicts observed", mon_hits, 9);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule